// File: doc/BRIEF.md
# Idle Wake-Up Interval Timer

This block keeps a 16-bit down-counter running for as long as the chip is out of reset. The counter moves down by one on every clock edge where the instruction-cycle strobe is high. Software cannot read the count or load it. Software chooses which of five high-order counter bits the block watches. When that bit falls from 1 to 0, the block raises a wake event. This gives a periodic tick every 4096, 8192, 16384, 32768 or 65536 instruction cycles.

Each wake event sets a sticky pending flag and clears the core's idle-request bit, so a core sleeping in idle mode resumes. The block drives an interrupt request while three things are all set: the pending flag, the timer's own enable and the global interrupt enable. The idle-request bit is held inside the block. The core sets it through a write strobe, and wake events clear it.

Changing the period select can cause one spurious event. This happens when the bit last sampled under the old select was 1 and the newly selected bit is 0. Software is expected to mask the interrupt and clear the pending flag around a change of period.

Top module: `idle_wake_timer`

## Requirements
- R1: After a synchronous reset, `pend`, `tmr_en`, `idle_req` and `irq` are all 0. The internal count restarts at all ones (0xFFFF).
- R2: The count decrements by one, wrapping from 0 to 0xFFFF, on each clock edge where `cyc_stb` is 1. It holds on every other edge.
- R3: `per_sel` selects the watched count bit: 000 selects bit 11, 001 bit 12, 010 bit 13, 011 bit 14, and any value 1xx selects bit 15.
- R4: On every strobed edge the block samples the watched bit. A wake event occurs on a strobed edge when the previous sample was 1 and the watched bit is now 0. After reset with `per_sel`=000 and a strobe on every cycle, `pend` is still 0 after 2048 strobes and is 1 after the 2049th.
- R5: With a fixed select value s, consecutive events are 2^(12+s) strobes apart (2^16 for s of 4 or more). For s=010, the first event after reset comes at strobe 8193.
- R6: A wake event sets `pend`. A cycle with `pend_clr`=1 and no event clears `pend`. When both occur on the same edge, the set wins.
- R7: A wake event clears `idle_req`. A cycle with `idle_set`=1 and no event sets `idle_req`. When both occur on the same edge, the clear wins.
- R8: `irq` is 1 exactly when `pend`, `tmr_en` and `gie` are all 1.
- R9: On an edge where `en_wr` is 1, `tmr_en` takes the value of `en_wdata`. Otherwise `tmr_en` holds.
- R10: A change of `per_sel` produces one event on the next strobe when the last sample of the old bit was 1 and the newly selected bit is 0. This is a spurious event.
- R11: While `cyc_stb` is 0, no event occurs, however long the strobe stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_stb | input | 1 | Instruction-cycle strobe; one count step per strobed edge |
| per_sel | input | 3 | Wake period select |
| en_wr | input | 1 | Write strobe for the timer interrupt enable |
| en_wdata | input | 1 | Value written to the enable |
| pend_clr | input | 1 | Clears the pending flag (write-zero action) |
| gie | input | 1 | Global interrupt enable |
| idle_set | input | 1 | Core request to enter idle mode |
| pend | output | 1 | Sticky wake-event pending flag |
| tmr_en | output | 1 | Timer interrupt enable state |
| irq | output | 1 | Interrupt request |
| idle_req | output | 1 | Idle-mode request bit |

## Verification
On every cycle, the embedded assertions check the following:
- the count step and the count hold;
- the flag priorities between a wake event and a software set or clear;
- enable retention;
- that any event seen under an unchanged select lands where the bits below the watched bit are all ones.

Only the bench scenarios can show the wake event timing:
- the exact strobe count of the first event;
- the spacing between events for each select value;
- the spurious event on a select change;
- the absence of events during long strobe gaps.

The bench shows these by comparing the ports against a cycle-level reference model and by directed timing checks.

// File: rtl/iwt_pkg.sv
package iwt_pkg;

    localparam int IWT_CNT_W  = 16;
    localparam int IWT_SEL_W  = 3;
    localparam int IWT_TAP_LO = 11;
    localparam int IWT_N_TAPS = 5;

    typedef struct packed {
        logic pend;
        logic en;
        logic idle;
    } iwt_flags_t;

    // Map a period select onto a tap slot; large selects saturate at the top slot.
    function automatic int unsigned tap_slot(int unsigned sel, int unsigned n_taps);
        return (sel >= n_taps - 1) ? (n_taps - 1) : sel;
    endfunction

endpackage

// File: rtl/iwt_counter.sv
module iwt_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    output logic [CNT_W-1:0] cnt
);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '1;
        else if (step)
            cnt <= cnt - CNT_W'(1);
    end

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        step |=> cnt == CNT_W'($past(cnt) - CNT_W'(1)));

    // R2
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(cnt));

endmodule

// File: rtl/iwt_tap_detect.sv
module iwt_tap_detect
    import iwt_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int SEL_W  = 3,
    parameter int TAP_LO = 11,
    parameter int N_TAPS = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic [SEL_W-1:0] sel,
    input  logic [CNT_W-1:0] cnt,
    output logic             evt
);

    localparam int IDX_W  = (N_TAPS > 1) ? $clog2(N_TAPS) : 1;
    localparam int SLOTS  = 1 << IDX_W;

    logic [SLOTS-1:0] taps;
    logic [IDX_W-1:0] idx;
    logic             cur;
    logic             prev;

    for (genvar g = 0; g < SLOTS; g++) begin : g_tap
        localparam int BIT = TAP_LO + ((g < N_TAPS) ? g : (N_TAPS - 1));
        assign taps[g] = cnt[BIT];
    end

    always_comb begin
        idx = IDX_W'(tap_slot(32'(sel), N_TAPS));
        cur = taps[idx];
    end

    always_ff @(posedge clk) begin
        if (rst)
            prev <= 1'b0;
        else if (step)
            prev <= cur;
    end

    assign evt = step & prev & ~cur;

    // Select in force at the last sample, kept for the alignment check below.
    logic [IDX_W-1:0] idx_q;
    logic [CNT_W-1:0] low_mask;

    always_ff @(posedge clk) begin
        if (rst)
            idx_q <= '0;
        else if (step)
            idx_q <= idx;
    end

    always_comb low_mask = (CNT_W'(1) << (TAP_LO + 32'(idx))) - CNT_W'(1);

    // R3
    tap_align_chk: assert property (@(posedge clk) disable iff (rst)
        (evt && idx == idx_q) |-> ((cnt & low_mask) == low_mask));

    // R11
    no_evt_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(prev));

endmodule

// File: rtl/iwt_flags.sv
module iwt_flags
    import iwt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic evt,
    input  logic pend_clr,
    input  logic en_wr,
    input  logic en_wdata,
    input  logic idle_set,
    input  logic gie,
    output logic pend,
    output logic en,
    output logic idle,
    output logic irq
);

    iwt_flags_t st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            if (evt)
                st.pend <= 1'b1;
            else if (pend_clr)
                st.pend <= 1'b0;

            if (en_wr)
                st.en <= en_wdata;

            if (evt)
                st.idle <= 1'b0;
            else if (idle_set)
                st.idle <= 1'b1;
        end
    end

    assign pend = st.pend;
    assign en   = st.en;
    assign idle = st.idle;
    assign irq  = st.pend & st.en & gie;

    // R6
    pend_set_chk: assert property (@(posedge clk) disable iff (rst)
        evt |=> pend);

    // R6
    pend_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (!evt && pend_clr) |=> !pend);

    // R7
    idle_drop_chk: assert property (@(posedge clk) disable iff (rst)
        evt |=> !idle);

    // R7
    idle_set_chk: assert property (@(posedge clk) disable iff (rst)
        (!evt && idle_set) |=> idle);

    // R9
    en_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !en_wr |=> $stable(en));

endmodule

// File: rtl/idle_wake_timer.sv
module idle_wake_timer
    import iwt_pkg::*;
#(
    parameter int CNT_W  = IWT_CNT_W,
    parameter int SEL_W  = IWT_SEL_W,
    parameter int TAP_LO = IWT_TAP_LO,
    parameter int N_TAPS = IWT_N_TAPS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cyc_stb,
    input  logic [SEL_W-1:0] per_sel,
    input  logic             en_wr,
    input  logic             en_wdata,
    input  logic             pend_clr,
    input  logic             gie,
    input  logic             idle_set,
    output logic             pend,
    output logic             tmr_en,
    output logic             irq,
    output logic             idle_req
);

    logic [CNT_W-1:0] cnt;
    logic             evt;

    iwt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .step (cyc_stb),
        .cnt  (cnt)
    );

    iwt_tap_detect #(
        .CNT_W  (CNT_W),
        .SEL_W  (SEL_W),
        .TAP_LO (TAP_LO),
        .N_TAPS (N_TAPS)
    ) u_tap (
        .clk  (clk),
        .rst  (rst),
        .step (cyc_stb),
        .sel  (per_sel),
        .cnt  (cnt),
        .evt  (evt)
    );

    iwt_flags u_flags (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .pend_clr (pend_clr),
        .en_wr    (en_wr),
        .en_wdata (en_wdata),
        .idle_set (idle_set),
        .gie      (gie),
        .pend     (pend),
        .en       (tmr_en),
        .idle     (idle_req),
        .irq      (irq)
    );

    // R11
    quiet_without_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (!cyc_stb && !pend_clr) |=> $stable(pend));

endmodule

// File: tb/idle_wake_timer_bench.sv
module idle_wake_timer_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cyc_stb = 1'b0;
    logic [2:0] per_sel = 3'd0;
    logic       en_wr = 1'b0;
    logic       en_wdata = 1'b0;
    logic       pend_clr = 1'b0;
    logic       gie = 1'b0;
    logic       idle_set = 1'b0;
    logic       pend, tmr_en, irq, idle_req;

    always #10 clk = ~clk;

    idle_wake_timer u_idle_wake_timer (
        .clk(clk), .rst(rst), .cyc_stb(cyc_stb), .per_sel(per_sel),
        .en_wr(en_wr), .en_wdata(en_wdata), .pend_clr(pend_clr), .gie(gie),
        .idle_set(idle_set), .pend(pend), .tmr_en(tmr_en), .irq(irq),
        .idle_req(idle_req)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // Reference model state, built from the requirements
    logic [15:0] m_cnt  = 16'hFFFF;
    logic        m_prev = 1'b0;
    logic        m_pend = 1'b0;
    logic        m_en   = 1'b0;
    logic        m_idle = 1'b0;

    // Phase table: sel, strobe stride, cycles, enable, gie
    typedef struct packed {
        logic [2:0]  sel;
        logic [3:0]  stride;
        logic [19:0] ncyc;
        logic        en;
        logic        g;
    } phase_t;

    localparam int NPH = 7;
    localparam phase_t PHASES [NPH] = '{
        '{3'd0, 4'd1, 20'd9000,  1'b1, 1'b1},
        '{3'd1, 4'd1, 20'd9000,  1'b0, 1'b1},
        '{3'd2, 4'd3, 20'd30000, 1'b1, 1'b0},
        '{3'd3, 4'd1, 20'd40000, 1'b1, 1'b1},
        '{3'd4, 4'd1, 20'd40000, 1'b1, 1'b1},
        '{3'd7, 4'd2, 20'd8000,  1'b1, 1'b1},
        '{3'd0, 4'd1, 20'd3000,  1'b1, 1'b1}
    };

    function automatic int tap_of(logic [2:0] s);
        return s[2] ? 15 : 11 + int'(s);
    endfunction

    task automatic chk(string req, string what, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic chk_int(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One clock: update the model at the edge, compare at the falling edge
    task automatic tick();
        logic cur, fall;
        @(posedge clk);
        if (rst) begin
            m_cnt = 16'hFFFF; m_prev = 1'b0; m_pend = 1'b0; m_en = 1'b0; m_idle = 1'b0;
        end else begin
            cur  = m_cnt[tap_of(per_sel)];
            fall = cyc_stb && m_prev && !cur;
            if (cyc_stb) begin
                m_prev = cur;
                m_cnt  = m_cnt - 16'd1;
            end
            if (fall) m_pend = 1'b1;
            else if (pend_clr) m_pend = 1'b0;
            if (en_wr) m_en = en_wdata;
            if (fall) m_idle = 1'b0;
            else if (idle_set) m_idle = 1'b1;
        end
        @(negedge clk);
        chk("R6", "pend vs model", pend, m_pend);
        chk("R9", "tmr_en vs model", tmr_en, m_en);
        chk("R7", "idle_req vs model", idle_req, m_idle);
        chk("R8", "irq vs model", irq, m_pend & m_en & gie);
    endtask

    task automatic do_reset();
        rst = 1'b1; cyc_stb = 1'b0; pend_clr = 1'b0; idle_set = 1'b0;
        en_wr = 1'b0; en_wdata = 1'b0; gie = 1'b0;
        tick(); tick();
        rst = 1'b0;
    endtask

    initial begin : watchdog
        repeat (195000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run did not finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin : main
        int k1, k2, k;
        @(negedge clk);
        do_reset();

        // R1: reset state
        chk("R1", "pend after reset", pend, 1'b0);
        chk("R1", "tmr_en after reset", tmr_en, 1'b0);
        chk("R1", "idle_req after reset", idle_req, 1'b0);
        chk("R1", "irq after reset", irq, 1'b0);

        // R4 / R11 / R6 / R7 / R8: first event timing and flag priorities
        per_sel = 3'd0; cyc_stb = 1'b1;
        repeat (2048) tick();
        chk("R4", "pend before 2049th strobe", pend, 1'b0);
        cyc_stb = 1'b0;
        repeat (3000) tick();
        chk("R11", "no event while strobe low", pend, 1'b0);
        idle_set = 1'b1; tick(); idle_set = 1'b0;
        chk("R7", "idle_set raises idle_req", idle_req, 1'b1);
        cyc_stb = 1'b1; pend_clr = 1'b1; idle_set = 1'b1;
        tick();
        cyc_stb = 1'b0; pend_clr = 1'b0; idle_set = 1'b0;
        chk("R4", "pend on 2049th strobe", pend, 1'b1);
        chk("R6", "set beats clear", pend, 1'b1);
        chk("R7", "event clear beats idle_set", idle_req, 1'b0);
        en_wr = 1'b1; en_wdata = 1'b1; gie = 1'b0;
        tick(); en_wr = 1'b0;
        chk("R9", "enable written", tmr_en, 1'b1);
        chk("R8", "irq masked by gie", irq, 1'b0);
        gie = 1'b1; #1;
        chk("R8", "irq with all three set", irq, 1'b1);
        pend_clr = 1'b1; tick(); pend_clr = 1'b0;
        chk("R6", "clear without event", pend, 1'b0);
        chk("R8", "irq drops with pend", irq, 1'b0);

        // R10: select change spurious event
        do_reset();
        per_sel = 3'd1; cyc_stb = 1'b1;
        repeat (2100) tick();
        chk("R10", "no event on bit 12 yet", pend, 1'b0);
        per_sel = 3'd0;
        tick();
        chk("R10", "spurious event after select change", pend, 1'b1);

        // R5 / R3: spacing for select 010 (bit 13)
        do_reset();
        per_sel = 3'd2; cyc_stb = 1'b1;
        k = 0; k1 = 0; k2 = 0;
        while (k2 == 0 && k < 30000) begin
            tick(); k++;
            pend_clr = 1'b0;
            if (pend) begin
                if (k1 == 0) k1 = k; else k2 = k;
                pend_clr = 1'b1;
            end
        end
        pend_clr = 1'b0;
        chk_int("R5", "first event strobe for select 010", k1, 8193);
        chk_int("R3", "period for select 010 (bit 13)", k2 - k1, 16384);

        // R2 / R3 / R5 and all flags: table of phases against the model
        do_reset();
        for (int p = 0; p < NPH; p++) begin
            per_sel = PHASES[p].sel; gie = PHASES[p].g;
            en_wr = 1'b1; en_wdata = PHASES[p].en; pend_clr = 1'b1; cyc_stb = 1'b0;
            tick();
            en_wr = 1'b0; pend_clr = 1'b0;
            for (int c = 1; c <= int'(PHASES[p].ncyc); c++) begin
                cyc_stb  = (c % int'(PHASES[p].stride)) == 0;
                pend_clr = (c % 1500) == 700;
                idle_set = (c % 1000) == 10;
                tick();
            end
            cyc_stb = 1'b0; pend_clr = 1'b0; idle_set = 1'b0;
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule